// File: doc/BRIEF.md
# Bytecode Stack Execution Core

This block is a compact multicycle processor core for a small set of stack-machine bytecodes. It reads opcode and operand bytes from a program memory that is one byte wide. It keeps its operand stack in a separate data memory that is one word wide and addressed by word. Both memories sit outside the core. Each has a synchronous read port with one cycle of latency. The data memory also has a write strobe.

The core caches the top stack element in a register. Every arithmetic or stack-shuffling bytecode therefore runs as a fixed chain of micro-steps. These steps pass through an address register and a data register in front of the data memory, with a holding register for the second operand.

A pulse on `start` initialises the stack pointers and the program counter, and execution begins at program address 0. Execution continues until the core fetches a byte that is not a supported opcode. The core then stops and reports the illegal opcode. Another `start` pulse runs the program again from the beginning.

Top module: `stack_core`

## Requirements
- R1: After reset the core is idle: `halted_o` and `illegal_o` are 0, `dmem_we_o` is 0, `tos_o` is 0, `prog_addr_o` is 0 and `sp_o` is 1023.
- R2: The clock edge that samples `start` while the core is idle or halted does four things. It sets the frame base to 1024 and `sp_o` to 1023. It sets the program counter to 0 and clears `illegal_o`. As a result, the first push lands at word address 1024.
- R3: Opcode 0x10 takes the following program byte and sign-extends it to 32 bits. It adds one to SP and writes the value at the new SP, and the value also becomes TOS.
- R4: Opcode 0x60 subtracts one from SP. It reads the word at the new SP, adds TOS modulo 2^32, and places the sum both in TOS and in memory at the new SP.
- R5: Opcode 0x64 works like 0x60 but computes the lower element minus the old TOS, modulo 2^32.
- R6: Opcodes 0x7E and 0xB0 work like 0x60 but compute the bitwise AND and the bitwise OR of the two 32-bit words.
- R7: Opcode 0x57 subtracts one from SP and loads TOS from the word at the new SP, without writing memory.
- R8: Opcode 0x59 adds one to SP and writes TOS at the new SP. TOS itself is left unchanged.
- R9: Opcode 0x5F leaves SP as it is. It writes the word found at SP-1 to address SP and the old TOS to address SP-1, and then TOS takes the word that was at SP-1. The core never writes any address other than SP or SP-1.
- R10: Opcode 0x00 changes nothing except advancing the program counter.
- R11: Any opcode byte outside {0x00, 0x10, 0x57, 0x59, 0x5F, 0x60, 0x64, 0x7E, 0xB0} stops the core. The core raises `halted_o` and `illegal_o`, leaves `prog_addr_o` one past the offending byte, performs no further memory writes, and holds that state until the next `start`.
- R12: Instruction cost, counting the fetch: 0x00 takes 3 cycles, 0x10 and 0x57 take 7, 0x59 takes 6, the four two-operand opcodes take 8 and 0x5F takes 10. `halted_o` goes high 3 cycles after the illegal opcode's fetch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin execution at program address 0 |
| prog_addr_o | output | 8 | Program byte address (program counter) |
| prog_data_i | input | 8 | Program byte, valid one cycle after the address |
| dmem_addr_o | output | 11 | Data word address |
| dmem_wdata_o | output | 32 | Data word to write |
| dmem_we_o | output | 1 | Data write strobe |
| dmem_rdata_i | input | 32 | Data word read, valid one cycle after the address |
| halted_o | output | 1 | Core has stopped |
| illegal_o | output | 1 | The stop was caused by an unsupported opcode |
| sp_o | output | 11 | Stack pointer |
| frame_o | output | 11 | Frame base pointer |
| tos_o | output | 32 | Cached top-of-stack word |

## Verification
Each program is launched with a one-cycle `start` pulse. The edge that samples the pulse is counted as edge 0. SP and the illegal flag are checked one cycle later, 1 ns after that edge.

After the pulse, the bench counts clock edges until `halted_o` is seen at a falling edge. It compares the count with the sum of the per-opcode costs plus the three cycles of the stopping fetch. Only then does it read TOS, SP, the program counter and the stack words in its memory model. At that point every write has landed and no stale read data can mislead the check.

The sweeps push pairs of operands through all four two-operand opcodes, and every byte value outside the opcode set is tried as the first instruction.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam logic [7:0] OPC_NOP    = 8'h00;
  localparam logic [7:0] OPC_PUSHB  = 8'h10;
  localparam logic [7:0] OPC_DROP   = 8'h57;
  localparam logic [7:0] OPC_COPY   = 8'h59;
  localparam logic [7:0] OPC_XCHG   = 8'h5F;
  localparam logic [7:0] OPC_ADD    = 8'h60;
  localparam logic [7:0] OPC_SUB    = 8'h64;
  localparam logic [7:0] OPC_AND    = 8'h7E;
  localparam logic [7:0] OPC_OR     = 8'hB0;

  typedef enum logic [4:0] {
    ST_IDLE, ST_FETCH, ST_FETCH_W, ST_DECODE,
    ST_OPND, ST_OPND_W, ST_LOADIMM,
    ST_MARLD, ST_RD, ST_RD_W, ST_ALU, ST_COPYD, ST_WR,
    ST_XA, ST_XWA, ST_XB, ST_XWB, ST_XT,
    ST_HALT
  } state_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_PASS
  } alu_op_t;

  function automatic logic is_binop(input logic [7:0] op);
    return (op == OPC_ADD) || (op == OPC_SUB) || (op == OPC_AND) || (op == OPC_OR);
  endfunction

  function automatic logic is_known(input logic [7:0] op);
    return is_binop(op) || (op == OPC_NOP) || (op == OPC_PUSHB) ||
           (op == OPC_DROP) || (op == OPC_COPY) || (op == OPC_XCHG);
  endfunction

  function automatic alu_op_t alu_sel(input logic [7:0] op);
    case (op)
      OPC_ADD: return ALU_ADD;
      OPC_SUB: return ALU_SUB;
      OPC_AND: return ALU_AND;
      OPC_OR:  return ALU_OR;
      default: return ALU_PASS;
    endcase
  endfunction

endpackage

// File: rtl/stk_alu.sv
module stk_alu #(
  parameter int DATA_W = 32
) (
  input  stk_pkg::alu_op_t    op,
  input  logic [DATA_W-1:0]   lower,
  input  logic [DATA_W-1:0]   upper,
  output logic [DATA_W-1:0]   y
);
  import stk_pkg::*;

  always_comb begin
    case (op)
      ALU_ADD: y = lower + upper;
      ALU_SUB: y = lower - upper;
      ALU_AND: y = lower & upper;
      ALU_OR:  y = lower | upper;
      default: y = lower;
    endcase
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [7:0]     opcode,
  output stk_pkg::state_t state_o
);
  import stk_pkg::*;

  state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_HALT: if (start) st_d = ST_FETCH;
      ST_FETCH:   st_d = ST_FETCH_W;
      ST_FETCH_W: st_d = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OPC_NOP)                         st_d = ST_FETCH;
        else if (opcode == OPC_PUSHB)                  st_d = ST_OPND;
        else if (opcode == OPC_XCHG)                   st_d = ST_RD;
        else if (is_binop(opcode) || opcode == OPC_DROP ||
                 opcode == OPC_COPY)                   st_d = ST_MARLD;
        else                                           st_d = ST_HALT;
      end
      ST_OPND:    st_d = ST_OPND_W;
      ST_OPND_W:  st_d = ST_LOADIMM;
      ST_LOADIMM: st_d = ST_WR;
      ST_MARLD:   st_d = (opcode == OPC_COPY) ? ST_COPYD : ST_RD;
      ST_RD:      st_d = ST_RD_W;
      ST_RD_W:    st_d = (opcode == OPC_XCHG) ? ST_XA : ST_ALU;
      ST_ALU:     st_d = (opcode == OPC_DROP) ? ST_FETCH : ST_WR;
      ST_COPYD:   st_d = ST_WR;
      ST_WR:      st_d = ST_FETCH;
      ST_XA:      st_d = ST_XWA;
      ST_XWA:     st_d = ST_XB;
      ST_XB:      st_d = ST_XWB;
      ST_XWB:     st_d = ST_XT;
      ST_XT:      st_d = ST_FETCH;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/stack_core.sv
module stack_core #(
  parameter int PADDR_W    = 8,
  parameter int DADDR_W    = 11,
  parameter int DATA_W     = 32,
  parameter int STACK_BASE = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic [PADDR_W-1:0] prog_addr_o,
  input  logic [7:0]         prog_data_i,
  output logic [DADDR_W-1:0] dmem_addr_o,
  output logic [DATA_W-1:0]  dmem_wdata_o,
  output logic               dmem_we_o,
  input  logic [DATA_W-1:0]  dmem_rdata_i,
  output logic               halted_o,
  output logic               illegal_o,
  output logic [DADDR_W-1:0] sp_o,
  output logic [DADDR_W-1:0] frame_o,
  output logic [DATA_W-1:0]  tos_o
);
  import stk_pkg::*;

  localparam logic [DADDR_W-1:0] FRAME_INIT = DADDR_W'(STACK_BASE);
  localparam logic [DADDR_W-1:0] SP_INIT    = DADDR_W'(STACK_BASE - 1);
  localparam int                 EXT_W      = DATA_W - 8;

  state_t               st;
  logic [PADDR_W-1:0]   pc_q;
  logic [DADDR_W-1:0]   sp_q, lv_q, mar_q;
  logic [DATA_W-1:0]    tos_q, h_q, mdr_q, alu_y, imm_ext;
  logic [7:0]           mbr_q;
  logic                 ill_q;

  stk_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .opcode  (mbr_q),
    .state_o (st)
  );

  stk_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (alu_sel(mbr_q)),
    .lower (mdr_q),
    .upper (h_q),
    .y     (alu_y)
  );

  assign imm_ext = {{EXT_W{mbr_q[7]}}, mbr_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      sp_q  <= SP_INIT;
      lv_q  <= FRAME_INIT;
      mar_q <= '0;
      tos_q <= '0;
      h_q   <= '0;
      mdr_q <= '0;
      mbr_q <= '0;
      ill_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE, ST_HALT: begin
          if (start) begin
            pc_q  <= '0;
            sp_q  <= SP_INIT;
            lv_q  <= FRAME_INIT;
            ill_q <= 1'b0;
          end
        end
        ST_FETCH_W: begin
          mbr_q <= prog_data_i;
          pc_q  <= pc_q + 1'b1;
        end
        ST_DECODE: begin
          if (is_binop(mbr_q)) begin
            sp_q <= sp_q - 1'b1;
            h_q  <= tos_q;
          end else if (mbr_q == OPC_DROP) begin
            sp_q <= sp_q - 1'b1;
          end else if (mbr_q == OPC_COPY) begin
            sp_q <= sp_q + 1'b1;
          end else if (mbr_q == OPC_XCHG) begin
            mar_q <= sp_q - 1'b1;
          end else if (!is_known(mbr_q)) begin
            ill_q <= 1'b1;
          end
        end
        ST_OPND_W: begin
          mbr_q <= prog_data_i;
          pc_q  <= pc_q + 1'b1;
          sp_q  <= sp_q + 1'b1;
        end
        ST_LOADIMM: begin
          mar_q <= sp_q;
          mdr_q <= imm_ext;
          tos_q <= imm_ext;
        end
        ST_MARLD: mar_q <= sp_q;
        ST_RD_W:  mdr_q <= dmem_rdata_i;
        ST_ALU: begin
          tos_q <= alu_y;
          mdr_q <= alu_y;
        end
        ST_COPYD: mdr_q <= tos_q;
        ST_XA: begin
          mar_q <= sp_q;
          h_q   <= mdr_q;
        end
        ST_XB: begin
          mdr_q <= tos_q;
          mar_q <= sp_q - 1'b1;
        end
        ST_XT: tos_q <= h_q;
        default: ;
      endcase
    end
  end

  assign prog_addr_o  = pc_q;
  assign dmem_addr_o  = mar_q;
  assign dmem_wdata_o = mdr_q;
  assign dmem_we_o    = (st == ST_WR) || (st == ST_XWA) || (st == ST_XWB);
  assign halted_o     = (st == ST_HALT);
  assign illegal_o    = ill_q;
  assign sp_o         = sp_q;
  assign frame_o      = lv_q;
  assign tos_o        = tos_q;

  // R2: a sampled start leaves the pointers at their initial values
  assert_start_init_R2: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE || st == ST_HALT) && start) |=>
      (sp_o == SP_INIT && frame_o == FRAME_INIT && prog_addr_o == '0 && !illegal_o));

  // R9: every write targets the top slot or the one below it
  assert_write_near_top_R9: assert property (@(posedge clk) disable iff (rst)
    dmem_we_o |-> (dmem_addr_o == sp_o || dmem_addr_o == sp_o - 1'b1));

  // R7: while running, SP moves by at most one word per cycle
  assert_sp_step_R7: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && st != ST_HALT) |=>
      (sp_o == $past(sp_o) || sp_o == $past(sp_o) + 1'b1 || sp_o == $past(sp_o) - 1'b1));

  // R11: a stopped core does not write
  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !dmem_we_o);

  // R11: the stop and its cause persist until the next start
  assert_halt_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (halted_o && !start) |=> (halted_o && $stable(illegal_o) && $stable(prog_addr_o)));
endmodule

// File: tb/test_stack_core.sv
module test_stack_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  prog_addr;
  logic [7:0]  prog_data;
  logic [10:0] dmem_addr;
  logic [31:0] dmem_wdata, dmem_rdata;
  logic        dmem_we, halted, illegal;
  logic [10:0] sp, frame;
  logic [31:0] tos;

  int checks = 0;
  int failures = 0;

  logic [7:0]  pmem [256];
  logic [31:0] dmem [2048];

  always #2 clk = ~clk;

  stack_core i_stack_core (
    .clk(clk), .rst(rst), .start(start),
    .prog_addr_o(prog_addr), .prog_data_i(prog_data),
    .dmem_addr_o(dmem_addr), .dmem_wdata_o(dmem_wdata), .dmem_we_o(dmem_we),
    .dmem_rdata_i(dmem_rdata), .halted_o(halted), .illegal_o(illegal),
    .sp_o(sp), .frame_o(frame), .tos_o(tos)
  );

  always_ff @(posedge clk) begin
    prog_data <= pmem[prog_addr];
    if (dmem_we) dmem[dmem_addr] <= dmem_wdata;
    dmem_rdata <= dmem[dmem_addr];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(input logic [7:0] b);
    return {{24{b[7]}}, b};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) pmem[i] = 8'hFF;
  endtask

  task automatic run_prog(output int cyc);
    int n;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    chk("R2 sp after start", {21'd0, sp}, 32'd1023);
    chk("R2 frame after start", {21'd0, frame}, 32'd1024);
    chk("R2 illegal cleared", {31'd0, illegal}, 32'd0);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!halted && n < 2000);
    cyc = n;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] vals [8];
    logic [7:0] ops [4];
    logic [31:0] a, b, r;
    vals = '{8'h00, 8'h01, 8'h02, 8'h7F, 8'h80, 8'hFF, 8'h55, 8'hAA};
    ops  = '{8'h60, 8'h64, 8'h7E, 8'hB0};
    clear_prog();
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 halted", {31'd0, halted}, 32'd0);
    chk("R1 illegal", {31'd0, illegal}, 32'd0);
    chk("R1 we", {31'd0, dmem_we}, 32'd0);
    chk("R1 tos", tos, 32'd0);
    chk("R1 pc", {24'd0, prog_addr}, 32'd0);
    chk("R1 sp", {21'd0, sp}, 32'd1023);

    // R11/R12: every unsupported first byte stops after 3 cycles
    for (int op = 0; op < 256; op++) begin
      logic [7:0] o;
      o = 8'(op);
      if (o == 8'h00 || o == 8'h10 || o == 8'h57 || o == 8'h59 || o == 8'h5F ||
          o == 8'h60 || o == 8'h64 || o == 8'h7E || o == 8'hB0) continue;
      clear_prog();
      pmem[0] = o;
      run_prog(cyc);
      chk("R12 illegal stop cycles", 32'(cyc), 32'd3);
      chk("R11 illegal flag", {31'd0, illegal}, 32'd1);
      chk("R11 pc past byte", {24'd0, prog_addr}, 32'd1);
      chk("R11 sp untouched", {21'd0, sp}, 32'd1023);
    end

    // R3..R6, R12: operand sweep through the two-operand opcodes
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          clear_prog();
          pmem[0] = 8'h10; pmem[1] = vals[i];
          pmem[2] = 8'h10; pmem[3] = vals[j];
          pmem[4] = ops[k];
          a = sx(vals[i]);
          b = sx(vals[j]);
          case (k)
            0: r = a + b;
            1: r = a - b;
            2: r = a & b;
            default: r = a | b;
          endcase
          run_prog(cyc);
          chk("R12 two-operand program cycles", 32'(cyc), 32'd25);
          chk("R3 pushed second operand", dmem[1025], b);
          case (k)
            0: chk("R4 add tos", tos, r);
            1: chk("R5 sub tos", tos, r);
            default: chk("R6 logic tos", tos, r);
          endcase
          chk("R4 result stored at sp", dmem[1024], r);
          chk("R4 sp after op", {21'd0, sp}, 32'd1024);
          chk("R11 pc at end", {24'd0, prog_addr}, 32'd6);
        end
      end
    end

    // R3, R7, R8, R9, R10, R12: mixed stack shuffle program
    clear_prog();
    pmem[0] = 8'h10; pmem[1] = 8'h05;
    pmem[2] = 8'h59;
    pmem[3] = 8'h10; pmem[4] = 8'hFD;
    pmem[5] = 8'h5F;
    pmem[6] = 8'h57;
    pmem[7] = 8'h00;
    run_prog(cyc);
    chk("R12 mixed program cycles", 32'(cyc), 32'd43);
    chk("R7 tos after drop", tos, 32'hFFFF_FFFD);
    chk("R7 sp after drop", {21'd0, sp}, 32'd1025);
    chk("R3 first push at base", dmem[1024], 32'd5);
    chk("R9 lower slot after exchange", dmem[1025], 32'hFFFF_FFFD);
    chk("R9 upper slot after exchange", dmem[1026], 32'd5);
    chk("R10 pc after nop", {24'd0, prog_addr}, 32'd9);

    // R8: copy keeps TOS and writes it above
    clear_prog();
    pmem[0] = 8'h10; pmem[1] = 8'h80;
    pmem[2] = 8'h59;
    run_prog(cyc);
    chk("R12 copy program cycles", 32'(cyc), 32'd16);
    chk("R8 tos unchanged", tos, 32'hFFFF_FF80);
    chk("R8 copy written", dmem[1025], 32'hFFFF_FF80);
    chk("R8 sp after copy", {21'd0, sp}, 32'd1025);

    // R10: nops only
    clear_prog();
    pmem[0] = 8'h00; pmem[1] = 8'h00; pmem[2] = 8'h00;
    run_prog(cyc);
    chk("R10 nop cycles", 32'(cyc), 32'd12);
    chk("R10 sp unchanged", {21'd0, sp}, 32'd1023);
    chk("R10 tos unchanged", tos, 32'hFFFF_FF80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule